// File: doc/BRIEF.md
# Register-List Stack Sequencer

This block moves a chosen subset of eight 16-bit word registers to or from a byte-wide stack memory with a single request. An 8-bit selection mask picks the registers. A direction input chooses between storing to the stack and loading from it. The sequencer takes the current stack pointer when it accepts a request. It then works through the selected registers one byte per cycle, splitting words into bytes or joining bytes into words. When it finishes, it returns the new stack pointer together with a one-cycle completion pulse.

A CPU control unit uses the block for multi-register save and restore. The control unit pulses the start input with the mask, direction and stack pointer, and waits for the completion pulse. It then copies the returned pointer into its own stack pointer register. The memory read data and the register-file read data are both combinational responses to the addresses that the block drives in the same cycle.

Top module: `regl_stack_seq`

## Requirements
- R1: Mask bit i (bit 7 for register 7 through bit 0 for register 0) selects word register i. A register whose bit is 0 is neither read nor written, and keeps its contents.
- R2: A load (pop_i = 1) fills the selected registers in ascending register number. The lowest selected register receives the word at the accepted stack pointer. The pointer grows by 2 for each register, so loading two registers from 0x34FA returns 0x34FE.
- R3: Words are little-endian. The byte at the lower address is bits 7:0 and the byte at the next address is bits 15:8, so bytes 0x01 and 0x02 at 0x34FA and 0x34FB form 0x0201.
- R4: A store (pop_i = 0) writes the selected registers in descending register number. The pointer is decremented by 2 before each word, so the lowest selected register ends up at the returned pointer. A load with the same mask from that pointer restores every register exactly and returns the original pointer.
- R5: The memory port carries one byte per cycle, with two consecutive cycles per selected register. done_o is high for exactly one cycle, 2n+1 cycles after the clock edge that accepted start_i, where n is the number of selected registers.
- R6: An all-zero mask raises done_o in the cycle after acceptance. It makes no memory access and returns the accepted stack pointer unchanged.
- R7: Stack pointer and address arithmetic wrap modulo 2^16. A store of all eight registers from 0x0004 uses addresses 0xFFF4 to 0x0003 and returns 0xFFF4.
- R8: start_i is ignored while busy_o is high, which covers the whole span from acceptance through the done_o cycle. A request raised during that span does not change the running operation.
- R9: Outside an operation, mem_req_o and rf_we_o are low. sp_o holds the returned pointer from the done_o cycle until the next accepted request. After reset, sp_o is 0 and busy_o, done_o, mem_req_o and rf_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only when idle |
| pop_i | input | 1 | 1 = load registers from stack, 0 = store registers to stack |
| mask_i | input | 8 | Register selection mask, bit i = register i |
| sp_i | input | 16 | Stack pointer at request |
| mem_req_o | output | 1 | Memory byte access this cycle |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Memory read byte, combinational from mem_addr_o |
| rf_raddr_o | output | 3 | Register-file read index |
| rf_rdata_i | input | 16 | Register-file read word, combinational from rf_raddr_o |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 3 | Register-file write index |
| rf_wdata_o | output | 16 | Register-file write word |
| busy_o | output | 1 | Operation accepted and not yet finished |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 16 | Returned stack pointer |

## Verification
done_o is due exactly 2n+1 cycles after the edge that accepted start_i. The bench counts falling edges from that edge and compares the count with twice the popcount of the mask plus one, which is a single cycle for an empty mask. Memory and register-file writes happen on the rising edge at which the block presents them. The returned pointer and the memory and register contents are therefore compared on the falling edge of the done_o cycle, and again a few cycles later to confirm they hold. Every memory access during an operation is also checked against the address window that the expected pointer arithmetic predicts, and the accesses are counted.

// File: rtl/regl_stack_pkg.sv
package regl_stack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/regl_pick.sv
// Picks the next register from the remaining mask: lowest index, or highest when high_first_i.
module regl_pick #(
  parameter int NREG  = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  mask_i,
  input  logic             high_first_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |mask_i;
    if (high_first_i) begin
      for (int i = 0; i < NREG; i++)
        if (mask_i[i]) idx_o = IDX_W'(i);
    end else begin
      for (int i = NREG - 1; i >= 0; i--)
        if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/regl_addr.sv
// Byte address for the current phase and the pointer after the current word.
module regl_addr #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              pop_i,
  input  logic              phase_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] sp_next_o
);
  localparam logic [ADDR_W-1:0] WordBytes = ADDR_W'(2);

  logic [ADDR_W-1:0] base;

  always_comb begin
    base      = pop_i ? sp_i : sp_i - WordBytes;  // store pre-decrements
    addr_o    = base + ADDR_W'(phase_i);
    sp_next_o = pop_i ? sp_i + WordBytes : sp_i - WordBytes;
  end
endmodule

// File: rtl/regl_stack_seq.sv
module regl_stack_seq
  import regl_stack_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  pop_i,
  input  logic [NREG-1:0]       mask_i,
  input  logic [ADDR_W-1:0]     sp_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0]     mem_wdata_o,
  input  logic [BYTE_W-1:0]     mem_rdata_i,
  output logic [$clog2(NREG)-1:0] rf_raddr_o,
  input  logic [2*BYTE_W-1:0]   rf_rdata_i,
  output logic                  rf_we_o,
  output logic [$clog2(NREG)-1:0] rf_waddr_o,
  output logic [2*BYTE_W-1:0]   rf_wdata_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [ADDR_W-1:0]     sp_o
);
  localparam int IDX_W  = $clog2(NREG);
  localparam int WORD_W = 2 * BYTE_W;

  seq_state_e        state_q;
  logic              pop_q;
  logic [NREG-1:0]   mask_q;
  logic [ADDR_W-1:0] sp_q;
  logic              phase_q;
  logic [BYTE_W-1:0] lo_q;

  logic [IDX_W-1:0]  cur_idx;
  logic              cur_any;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] sp_next;
  logic [NREG-1:0]   mask_rest;
  logic              xfer;

  regl_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .mask_i       (mask_q),
    .high_first_i (~pop_q),
    .idx_o        (cur_idx),
    .any_o        (cur_any)
  );

  regl_addr #(.ADDR_W(ADDR_W)) u_addr (
    .sp_i      (sp_q),
    .pop_i     (pop_q),
    .phase_i   (phase_q),
    .addr_o    (addr),
    .sp_next_o (sp_next)
  );

  assign xfer      = (state_q == ST_XFER);
  assign mask_rest = mask_q & ~(NREG'(1) << cur_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pop_q   <= 1'b0;
      mask_q  <= '0;
      sp_q    <= '0;
      phase_q <= 1'b0;
      lo_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pop_q   <= pop_i;
          mask_q  <= mask_i;
          sp_q    <= sp_i;
          phase_q <= 1'b0;
          state_q <= (mask_i == '0) ? ST_DONE : ST_XFER;
        end
        ST_XFER: begin
          if (!phase_q) begin
            phase_q <= 1'b1;
            if (pop_q) lo_q <= mem_rdata_i;
          end else begin
            phase_q <= 1'b0;
            sp_q    <= sp_next;
            mask_q  <= mask_rest;
            if (mask_rest == '0) state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = xfer && cur_any;
    mem_we_o    = xfer && !pop_q;
    mem_addr_o  = addr;
    mem_wdata_o = phase_q ? rf_rdata_i[WORD_W-1:BYTE_W] : rf_rdata_i[BYTE_W-1:0];
    rf_raddr_o  = cur_idx;
    rf_we_o     = xfer && pop_q && phase_q;
    rf_waddr_o  = cur_idx;
    rf_wdata_o  = {mem_rdata_i, lo_q};
    busy_o      = (state_q != ST_IDLE);
    done_o      = (state_q == ST_DONE);
    sp_o        = sp_q;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_ADDR_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && phase_q) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R3

  AST_LOAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o) |=> (sp_o == $past(sp_o) + ADDR_W'(2))); // R2

  AST_STORE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && phase_q) |=> (sp_o == $past(sp_o) - ADDR_W'(2))); // R4

  AST_EMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && mask_i == '0) |=> (done_o && !mem_req_o && sp_o == $past(sp_i))); // R6

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(pop_q)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !rf_we_o)); // R9
endmodule

// File: tb/regl_stack_seq_tb.sv
`timescale 1ns/1ps
module regl_stack_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pop = 1'b0;
  logic [7:0]  mask = '0;
  logic [15:0] sp = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we, busy, done;
  logic [15:0] sp_out;

  logic [7:0]  mem [256];
  logic [15:0] rf [8];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int acc_cnt = 0;
  int bad_addr = 0;
  logic [15:0] win_lo = '0;
  logic [15:0] win_len = 16'd16;

  always #5 clk = ~clk;

  regl_stack_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pop_i(pop), .mask_i(mask), .sp_i(sp),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .busy_o(busy), .done_o(done), .sp_o(sp_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  assign rf_rdata  = rf[rf_raddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      acc_cnt <= acc_cnt + 1;
      if (16'(mem_addr - win_lo) >= win_len) bad_addr <= bad_addr + 1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
    if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Issues one request; returns falling edges from accepting edge to done.
  task automatic run_op(input bit p, input logic [7:0] m, input logic [15:0] s,
                        output int cycles);
    @(negedge clk);
    start = 1'b1; pop = p; mask = m; sp = s;
    acc_cnt = 0; bad_addr = 0;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 100) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  function automatic logic [15:0] pat(input int i, input int m);
    return 16'((i + 1) * 16'h1357) ^ 16'(m << 4) ^ 16'h8001;
  endfunction

  initial begin
    int cycles;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) rf[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we, "R9", "reset strobes", {busy, done, mem_req, rf_we}, 0);
    chk(sp_out == 16'h0, "R9", "reset sp", sp_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep every mask: store then load back.
    for (int m = 0; m < 256; m++) begin
      logic [15:0] s_top, s_low, a;
      int n;
      bit ok;
      n = $countones(m[7:0]);
      s_top = 16'h3500;
      s_low = 16'(s_top - 16'(2 * n));
      win_lo = 16'(s_top - 16'd16);
      for (int i = 0; i < 8; i++) rf[i] = pat(i, m);
      run_op(1'b0, m[7:0], s_top, cycles);
      chk(cycles == 2 * n + 1, (n == 0) ? "R6" : "R5", "store done cycle", cycles, 2 * n + 1);
      chk(sp_out == s_low, (n == 0) ? "R6" : "R4", "store sp", sp_out, s_low);
      chk(acc_cnt == 2 * n && bad_addr == 0, "R5", "store accesses", acc_cnt, 2 * n);
      ok = 1'b1;
      a = s_low;
      for (int i = 0; i < 8; i++) if (m[i]) begin
        if (mem[a[7:0]] != pat(i, m)[7:0] || mem[8'(a[7:0] + 8'd1)] != pat(i, m)[15:8]) ok = 1'b0;
        a = 16'(a + 16'd2);
      end
      chk(ok, "R3", "store byte layout", m, m);
      for (int i = 0; i < 8; i++) rf[i] = 16'hDE00 ^ 16'(i);
      run_op(1'b1, m[7:0], s_low, cycles);
      chk(cycles == 2 * n + 1 && acc_cnt == 2 * n, "R5", "load timing", cycles, 2 * n + 1);
      chk(sp_out == s_top, "R2", "load sp", sp_out, s_top);
      ok = 1'b1;
      for (int i = 0; i < 8; i++) begin
        if (m[i] && rf[i] != pat(i, m)) ok = 1'b0;
        if (!m[i] && rf[i] != (16'hDE00 ^ 16'(i))) ok = 1'b0;
      end
      chk(ok, "R1", "restored and skipped registers", m, m);
    end

    // Worked load example.
    win_lo = 16'h34FA; win_len = 16'd4;
    mem[8'hFA] = 8'h01; mem[8'hFB] = 8'h02; mem[8'hFC] = 8'h03; mem[8'hFD] = 8'h04;
    for (int i = 0; i < 8; i++) rf[i] = 16'h5A5A;
    run_op(1'b1, 8'h11, 16'h34FA, cycles);
    chk(rf[0] == 16'h0201, "R3", "low register word", rf[0], 16'h0201);
    chk(rf[4] == 16'h0403, "R2", "second register word", rf[4], 16'h0403);
    chk(rf[1] == 16'h5A5A && rf[3] == 16'h5A5A, "R1", "skipped register", rf[1], 16'h5A5A);
    chk(sp_out == 16'h34FE && bad_addr == 0, "R2", "example sp", sp_out, 16'h34FE);

    // Wrap through address zero.
    win_lo = 16'hFFF4; win_len = 16'd16;
    for (int i = 0; i < 8; i++) rf[i] = 16'h1111 * 16'(i + 1);
    run_op(1'b0, 8'hFF, 16'h0004, cycles);
    chk(sp_out == 16'hFFF4, "R7", "wrapped store sp", sp_out, 16'hFFF4);
    chk(bad_addr == 0 && acc_cnt == 16, "R7", "wrapped addresses", bad_addr, 0);
    for (int i = 0; i < 8; i++) rf[i] = 16'h0;
    run_op(1'b1, 8'hFF, 16'hFFF4, cycles);
    chk(sp_out == 16'h0004, "R7", "wrapped load sp", sp_out, 16'h0004);
    chk(rf[0] == 16'h1111 && rf[7] == 16'h8888, "R7", "wrapped restore", rf[7], 16'h8888);

    // Start raised while busy must be ignored.
    win_lo = 16'h34F0; win_len = 16'd16;
    @(negedge clk);
    start = 1'b1; pop = 1'b0; mask = 8'h03; sp = 16'h3500;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; pop = 1'b1; mask = 8'hFF; sp = 16'h1000;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && cycles < 100) begin @(negedge clk); cycles++; end
    chk(sp_out == 16'h34FC, "R8", "sp after ignored start", sp_out, 16'h34FC);
    start = 1'b1; pop = 1'b1; mask = 8'hFF; sp = 16'h2000;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !done, "R8", "start in done cycle ignored", busy, 0);
    repeat (3) @(negedge clk);
    chk(sp_out == 16'h34FC && !busy && !mem_req && !rf_we, "R9", "held sp when idle", sp_out, 16'h34FC);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule